// File: doc/BRIEF.md
# UART status and interrupt flag unit

This block keeps the status flags of a serial port and produces its receive and transmit interrupt requests. A receiver core signals it with single-cycle pulses: a byte has been loaded, the receiver lost a byte, a stop bit was bad, or a parity check failed. A transmitter core pulses it when the buffered byte moves into its shift register. Software reaches the block through a small register bus. It can read the received byte, write the next byte to send, write a control register and read or write a status register.

The receive-data-full and transmit-buffer-empty flags clear as side effects of bus accesses. The three receive error flags clear together when software writes zero to an error-clear bit. An operating-mode input decides which error flags can be set at all. If a set event and a clear event reach the same flag in one clock cycle, the set event wins. Both interrupt requests are combinational functions of the registered flags and their enables.

Top module: `uart_stat_irq`

## Requirements
- R1: After reset, the status register reads 0x10: transmit-buffer-empty is 1, every receive flag is 0 and both enables are 0. Both interrupt requests are 0 and the transmit data output is 0.
- R2: A `rxLoad` pulse stores `rxData` and sets the full flag (status bit 0). A read at address 0 returns the stored byte.
- R3: A bus read at address 0 clears the full flag. If `rxLoad` arrives in the same cycle, the flag stays 1.
- R4: The overrun flag (status bit 1) is set by an `ovrEvt` pulse. It is also set by `rxLoad` while the full flag is 1, unless address 0 is being read in that cycle. The newer byte replaces the stored byte.
- R5: `frmEvt` sets the framing flag (status bit 2) only in modes 0 and 1. `parEvt` sets the parity flag (status bit 3) only in mode 0. Modes 2 and 3 set neither flag.
- R6: Writing the control register (address 1) with bit 0 equal to 0 clears the overrun, framing and parity flags together. Writing bit 0 as 1 has no effect. An error event in the same cycle as the clear still sets its flag.
- R7: A `txMove` pulse sets the transmit-buffer-empty flag (status bit 4). A bus write at address 0 clears that flag and drives the written byte on `txData`. If `txMove` arrives in the same cycle as the write, the flag stays 1.
- R8: `rxIrq` is 1 exactly when the receive enable (status bit 6) is 1 and at least one of status bits 0 to 3 is 1.
- R9: `txIrq` is 1 exactly when the transmit enable (status bit 7) is 1 and status bit 4 is 1.
- R10: A status write (address 2) updates only bits 6 and 7; software cannot change the flag bits. Status bit 5 reads 0. The control register reads 0x01. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating mode 0..3, selects which error flags can be set |
| rxLoad | input | 1 | Pulse: receiver has a new byte on rxData |
| rxData | input | DATA_W | Byte from the receiver |
| ovrEvt | input | 1 | Pulse: receiver reports a lost byte |
| frmEvt | input | 1 | Pulse: receiver reports a framing error |
| parEvt | input | 1 | Pulse: receiver reports a parity error |
| txMove | input | 1 | Pulse: transmit byte moved into the shift register |
| busAddr | input | 2 | Register address: 0 data, 1 control, 2 status |
| busRd | input | 1 | Read strobe (side effect only at address 0) |
| busWr | input | 1 | Write strobe |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| txData | output | DATA_W | Byte held for the transmitter |
| rxIrq | output | 1 | Receive interrupt request |
| txIrq | output | 1 | Transmit interrupt request |

## Verification
The assertions check the following on every cycle:
- the flag-setting events take effect on the next edge;
- the framing and parity flags cannot become 1 in modes that exclude them;
- a group clear leaves all three error flags at 0;
- the enables stay fixed unless software writes the status register;
- both interrupt outputs agree with the status word whenever it is addressed.

Other behaviour needs the bench's scenarios:
- which flag wins when a set and a clear fall in the same cycle;
- that the newer byte overwrites the stored one;
- the exact register read values;
- that a control write with bit 0 set changes nothing.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  // status word bit positions
  localparam int ST_FULL = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_FRM  = 2;
  localparam int ST_PAR  = 3;
  localparam int ST_TXE  = 4;
  localparam int ST_RXIE = 6;
  localparam int ST_TXIE = 7;

  // control word: writing 0 here clears the error group
  localparam int CTL_ERRCLR = 0;

  typedef enum logic [1:0] {
    MODE_ALLERR = 2'd0,
    MODE_NOPAR  = 2'd1,
    MODE_NOFRM  = 2'd2,
    MODE_RSVD   = 2'd3
  } uartMode_e;

  // strobes handed from the control to the datapath
  typedef struct packed {
    logic wrData;
    logic selData;
    logic selCtl;
    logic selStat;
  } dpStrobe_t;

  typedef struct packed {
    logic rxFull;
    logic ovr;
    logic frm;
    logic par;
    logic txEmpty;
    logic rxIe;
    logic txIe;
  } flagSet_t;

endpackage

// File: rtl/uart_stat_ctl.sv
module uart_stat_ctl
  import uart_stat_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              mode,
  input  logic                    rxLoad,
  input  logic                    ovrEvt,
  input  logic                    frmEvt,
  input  logic                    parEvt,
  input  logic                    txMove,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busRd,
  input  logic                    busWr,
  input  logic                    errClrBit,
  input  logic                    rxIeBit,
  input  logic                    txIeBit,
  output dpStrobe_t               stb,
  output flagSet_t                flags,
  output logic                    rxIrq,
  output logic                    txIrq
);

  logic rdDataHit;
  logic errClrHit;
  logic wrStatHit;
  logic ovrHit;
  logic frmAllowed;
  logic parAllowed;
  uartMode_e modeE;
  flagSet_t flagD;

  assign modeE = uartMode_e'(mode);

  // bus decode
  always_comb begin
    stb.selData = (busAddr == ADDR_DATA);
    stb.selCtl  = (busAddr == ADDR_CTRL);
    stb.selStat = (busAddr == ADDR_STAT);
    stb.wrData  = busWr && stb.selData;
    rdDataHit   = busRd && stb.selData;
    errClrHit   = busWr && stb.selCtl && !errClrBit;
    wrStatHit   = busWr && stb.selStat;
  end

  // mode decides which error sources are live
  always_comb begin
    unique case (modeE)
      MODE_ALLERR: begin frmAllowed = 1'b1; parAllowed = 1'b1; end
      MODE_NOPAR:  begin frmAllowed = 1'b1; parAllowed = 1'b0; end
      default:     begin frmAllowed = 1'b0; parAllowed = 1'b0; end
    endcase
  end

  // a byte landing on a full buffer is an overrun unless software drains it now
  assign ovrHit = ovrEvt || (rxLoad && flags.rxFull && !rdDataHit);

  // clears first, sets after: set wins on collision
  always_comb begin
    flagD = flags;
    if (rdDataHit) flagD.rxFull = 1'b0;
    if (rxLoad)    flagD.rxFull = 1'b1;

    if (errClrHit) begin
      flagD.ovr = 1'b0;
      flagD.frm = 1'b0;
      flagD.par = 1'b0;
    end
    if (ovrHit)                 flagD.ovr = 1'b1;
    if (frmEvt && frmAllowed)   flagD.frm = 1'b1;
    if (parEvt && parAllowed)   flagD.par = 1'b1;

    if (stb.wrData) flagD.txEmpty = 1'b0;
    if (txMove)     flagD.txEmpty = 1'b1;

    if (wrStatHit) begin
      flagD.rxIe = rxIeBit;
      flagD.txIe = txIeBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags <= '{rxFull: 1'b0, ovr: 1'b0, frm: 1'b0, par: 1'b0,
                 txEmpty: 1'b1, rxIe: 1'b0, txIe: 1'b0};
    end else begin
      flags <= flagD;
    end
  end

  assign rxIrq = flags.rxIe && (flags.rxFull || flags.ovr || flags.frm || flags.par);
  assign txIrq = flags.txIe && flags.txEmpty;

endmodule

// File: rtl/uart_stat_dp.sv
module uart_stat_dp
  import uart_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              rxLoad,
  input  logic [DATA_W-1:0] rxData,
  input  logic [DATA_W-1:0] busWdata,
  input  flagSet_t          flags,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] txData
);

  logic [DATA_W-1:0] rxHold;
  logic [DATA_W-1:0] statWord;
  logic [DATA_W-1:0] ctlWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHold <= '0;
      txData <= '0;
    end else begin
      if (rxLoad)     rxHold <= rxData;
      if (stb.wrData) txData <= busWdata;
    end
  end

  always_comb begin
    statWord          = '0;
    statWord[ST_FULL] = flags.rxFull;
    statWord[ST_OVR]  = flags.ovr;
    statWord[ST_FRM]  = flags.frm;
    statWord[ST_PAR]  = flags.par;
    statWord[ST_TXE]  = flags.txEmpty;
    statWord[ST_RXIE] = flags.rxIe;
    statWord[ST_TXIE] = flags.txIe;

    ctlWord             = '0;
    ctlWord[CTL_ERRCLR] = 1'b1;
  end

  always_comb begin
    if (stb.selData)      busRdata = rxHold;
    else if (stb.selCtl)  busRdata = ctlWord;
    else if (stb.selStat) busRdata = statWord;
    else                  busRdata = '0;
  end

endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
  import uart_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              rxLoad,
  input  logic [DATA_W-1:0] rxData,
  input  logic              ovrEvt,
  input  logic              frmEvt,
  input  logic              parEvt,
  input  logic              txMove,
  input  logic [1:0]        busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] txData,
  output logic              rxIrq,
  output logic              txIrq
);

  dpStrobe_t stb;
  flagSet_t  flagQ;

  uart_stat_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (mode),
    .rxLoad    (rxLoad),
    .ovrEvt    (ovrEvt),
    .frmEvt    (frmEvt),
    .parEvt    (parEvt),
    .txMove    (txMove),
    .busAddr   (busAddr),
    .busRd     (busRd),
    .busWr     (busWr),
    .errClrBit (busWdata[CTL_ERRCLR]),
    .rxIeBit   (busWdata[ST_RXIE]),
    .txIeBit   (busWdata[ST_TXIE]),
    .stb       (stb),
    .flags     (flagQ),
    .rxIrq     (rxIrq),
    .txIrq     (txIrq)
  );

  uart_stat_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rxLoad   (rxLoad),
    .rxData   (rxData),
    .busWdata (busWdata),
    .flags    (flagQ),
    .busRdata (busRdata),
    .txData   (txData)
  );

endmodule

// File: rtl/uart_stat_chk.sv
module uart_stat_chk
  import uart_stat_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [1:0] mode,
  input logic       rxLoad,
  input logic       ovrEvt,
  input logic       frmEvt,
  input logic       parEvt,
  input logic       txMove,
  input logic [1:0] busAddr,
  input logic       busRd,
  input logic       busWr,
  input logic       errBit,
  input logic [7:0] rdByte,
  input flagSet_t   flags,
  input logic       rxIrq,
  input logic       txIrq
);

  p_full_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    rxLoad |=> flags.rxFull);

  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ovrEvt || (rxLoad && flags.rxFull && !(busRd && busAddr == ADDR_DATA))) |=> flags.ovr);

  p_frm_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode[1] && !flags.frm) |=> !flags.frm);

  p_par_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((mode != 2'd0) && !flags.par) |=> !flags.par);

  p_err_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_CTRL && !errBit && !ovrEvt && !rxLoad && !frmEvt && !parEvt)
      |=> (!flags.ovr && !flags.frm && !flags.par));

  p_tx_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    txMove |=> flags.txEmpty);

  p_rx_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_STAT) |-> (rxIrq == (rdByte[ST_RXIE] && (|rdByte[ST_PAR:ST_FULL]))));

  p_tx_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_STAT) |-> (txIrq == (rdByte[ST_TXIE] && rdByte[ST_TXE])));

  p_ien_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == ADDR_STAT) |=> ($stable(flags.rxIe) && $stable(flags.txIe)));

  p_spare_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_STAT) |-> !rdByte[5]);

endmodule

bind uart_stat_irq uart_stat_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .mode    (mode),
  .rxLoad  (rxLoad),
  .ovrEvt  (ovrEvt),
  .frmEvt  (frmEvt),
  .parEvt  (parEvt),
  .txMove  (txMove),
  .busAddr (busAddr),
  .busRd   (busRd),
  .busWr   (busWr),
  .errBit  (busWdata[0]),
  .rdByte  (busRdata[7:0]),
  .flags   (flagQ),
  .rxIrq   (rxIrq),
  .txIrq   (txIrq)
);

// File: tb/sim_uart_stat_irq.sv
module sim_uart_stat_irq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       rxLoad = 1'b0;
  logic [7:0] rxData = '0;
  logic       ovrEvt = 1'b0;
  logic       frmEvt = 1'b0;
  logic       parEvt = 1'b0;
  logic       txMove = 1'b0;
  logic [1:0] busAddr = 2'd3;
  logic       busRd = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] txData;
  logic       rxIrq;
  logic       txIrq;

  int vecCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  typedef struct {
    logic [17:0] mask;
    logic [17:0] val;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [17:0] obs;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_stat_irq #(.DATA_W(8)) u0 (
    .clk(clk), .rstN(rstN), .mode(mode), .rxLoad(rxLoad), .rxData(rxData),
    .ovrEvt(ovrEvt), .frmEvt(frmEvt), .parEvt(parEvt), .txMove(txMove),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .txData(txData), .rxIrq(rxIrq), .txIrq(txIrq)
  );

  assign obs = {rxIrq, txIrq, busRdata, txData};

  // monitor: compares queued expectations mid low phase
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        vecCnt++;
        if ((obs & e.mask) !== e.val) begin
          failCnt++;
          $display("FAIL %s: actual %h expected %h", e.tag, obs & e.mask, e.val);
        end
      end
    end
  end

  task automatic pushExp(input logic [17:0] mask, input logic [17:0] val, input string tag);
    expItem_t e;
    e.mask = mask;
    e.val  = val & mask;
    e.tag  = tag;
    expQ.push_back(e);
  endtask

  // start a new cycle with all strobes idle
  task automatic cyc();
    @(negedge clk);
    rxLoad = 1'b0; ovrEvt = 1'b0; frmEvt = 1'b0; parEvt = 1'b0; txMove = 1'b0;
    busRd = 1'b0; busWr = 1'b0; busAddr = 2'd3; busWdata = '0;
  endtask

  task automatic chkStat(input logic [7:0] v, input string tag);
    cyc();
    busAddr = 2'd2; busRd = 1'b1;
    pushExp(18'h0FF00, {2'b00, v, 8'h00}, tag);
  endtask

  task automatic chkIrq(input logic rx, input logic tx, input string tag);
    pushExp(18'h30000, {rx, tx, 16'h0000}, tag);
  endtask

  task automatic readData(input logic [7:0] v, input string tag);
    cyc();
    busAddr = 2'd0; busRd = 1'b1;
    pushExp(18'h0FF00, {2'b00, v, 8'h00}, tag);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    cyc();
    busAddr = a; busWr = 1'b1; busWdata = d;
  endtask

  task automatic loadByte(input logic [7:0] d);
    cyc();
    rxLoad = 1'b1; rxData = d;
  endtask

  task automatic errPulse(input logic [1:0] m, input logic o, input logic f, input logic p);
    cyc();
    mode = m; ovrEvt = o; frmEvt = f; parEvt = p;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual running expected finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkStat(8'h10, "R1 status after reset");
    pushExp(18'h300FF, 18'h0, "R1 irqs and txData after reset");

    // R10 status write touches only enables
    writeReg(2'd2, 8'hFF);
    chkStat(8'hD0, "R10 status write only enables");
    chkIrq(1'b0, 1'b1, "R9 tx irq with enable and empty");
    writeReg(2'd2, 8'h00);
    chkStat(8'h10, "R10 enables cleared");
    cyc(); busAddr = 2'd1;
    pushExp(18'h0FF00, {2'b00, 8'h01, 8'h00}, "R10 control reads 0x01");
    cyc(); busAddr = 2'd3;
    pushExp(18'h0FF00, 18'h0, "R10 address 3 reads zero");

    // R2 load and read back
    loadByte(8'hA5);
    chkStat(8'h11, "R2 full set after load");
    readData(8'hA5, "R2 data returned");
    chkStat(8'h10, "R3 full cleared by read");

    // R3 set wins over read clear, no overrun
    loadByte(8'h3C);
    readData(8'h3C, "R3 old byte on colliding read");
    rxLoad = 1'b1; rxData = 8'h5A;
    chkStat(8'h11, "R3 full kept when load meets read");
    readData(8'h5A, "R3 newer byte stored");
    chkStat(8'h10, "R3 drained");

    // R4 overrun by load on full buffer
    loadByte(8'h11);
    loadByte(8'h22);
    chkStat(8'h13, "R4 overrun on load while full");
    readData(8'h22, "R4 newer byte overwrote");
    chkStat(8'h12, "R4 overrun survives read");

    // R6 group clear
    writeReg(2'd1, 8'h01);
    chkStat(8'h12, "R6 write of 1 is no-op");
    writeReg(2'd1, 8'h00);
    chkStat(8'h10, "R6 errors cleared");

    // R4 overrun pulse
    errPulse(2'd0, 1'b1, 1'b0, 1'b0);
    chkStat(8'h12, "R4 overrun pulse");
    writeReg(2'd1, 8'h00);

    // R5 mode gating
    errPulse(2'd0, 1'b0, 1'b1, 1'b1);
    chkStat(8'h1C, "R5 mode0 sets frame and parity");
    writeReg(2'd1, 8'h00);
    errPulse(2'd1, 1'b0, 1'b1, 1'b1);
    chkStat(8'h14, "R5 mode1 frame only");
    writeReg(2'd1, 8'h00);
    errPulse(2'd2, 1'b0, 1'b1, 1'b1);
    chkStat(8'h10, "R5 mode2 neither");
    errPulse(2'd3, 1'b0, 1'b1, 1'b1);
    chkStat(8'h10, "R5 mode3 neither");

    // R6 event beats clear in same cycle
    errPulse(2'd0, 1'b0, 1'b1, 1'b0);
    writeReg(2'd1, 8'h00);
    parEvt = 1'b1;
    chkStat(8'h18, "R6 parity set wins, frame cleared");
    writeReg(2'd1, 8'h00);
    chkStat(8'h10, "R6 cleared again");

    // R8 receive irq
    writeReg(2'd2, 8'h40);
    chkStat(8'h50, "R8 rx enable set");
    chkIrq(1'b0, 1'b0, "R8 no rx irq without flags");
    loadByte(8'h99);
    cyc(); chkIrq(1'b1, 1'b0, "R8 rx irq on full");
    readData(8'h99, "R8 read data");
    chkIrq(1'b1, 1'b0, "R8 irq held until read takes effect");
    cyc(); chkIrq(1'b0, 1'b0, "R8 irq drops after read");
    errPulse(2'd0, 1'b0, 1'b0, 1'b1);
    cyc(); chkIrq(1'b1, 1'b0, "R8 rx irq on parity error");
    writeReg(2'd1, 8'h00);
    cyc(); chkIrq(1'b0, 1'b0, "R8 rx irq gone after clear");
    writeReg(2'd2, 8'h00);

    // R7 and R9 transmit side
    writeReg(2'd0, 8'h77);
    chkStat(8'h00, "R7 empty cleared by write");
    pushExp(18'h000FF, 18'h00077, "R7 txData holds written byte");
    writeReg(2'd2, 8'h80);
    chkStat(8'h80, "R9 tx enable set, buffer full");
    chkIrq(1'b0, 1'b0, "R9 no tx irq while full");
    cyc(); txMove = 1'b1;
    chkStat(8'h90, "R7 txMove sets empty");
    chkIrq(1'b0, 1'b1, "R9 tx irq after move");
    writeReg(2'd0, 8'h88);
    txMove = 1'b1;
    chkStat(8'h90, "R7 move beats write clear");
    pushExp(18'h000FF, 18'h00088, "R7 txData updated");

    repeat (3) cyc();
    done = 1'b1;
    finishRun();
  end

endmodule